// File: doc/BRIEF.md
# Dual-Mode Serial Clock Tick Generator

This block derives the bit-rate enable for a serial shift engine from the module clock. A single control word holds two divide settings and one mode bit. In linear mode the serial clock runs at the module clock divided by 2×(N+1). In power-of-two mode it runs at the module clock divided by 2^E. The block does not produce the serial clock itself. It emits a one-cycle enable pulse at twice the serial clock rate, and the shift engine toggles its clock once on each pulse. Phase and idle polarity are handled by the engine.

The engine holds `en_i` high while a transfer is running and pulses `start_i` when a transfer begins. A start pulse, a control write, or a low enable all return the internal count to zero. The first pulse after a restart therefore comes exactly one tick period later, with no truncated first half-cycle.

Top module: `spi_tick_gen`

## Requirements
- R1: After reset `tick_o` is low and `cfg_rdata_o` reads zero, which selects power-of-two mode with exponent 0.
- R2: Control word layout: bits [7:0] hold the linear divisor N, bits [11:8] hold the exponent E, and bit 12 selects the mode (1 = linear, 0 = power-of-two). A write is read back on `cfg_rdata_o` from the following cycle onwards.
- R3: In linear mode `tick_o` pulses once every N+1 module clock cycles, which gives a serial clock of the module clock divided by 2×(N+1).
- R4: In power-of-two mode with E ≥ 1, `tick_o` pulses once every 2^(E-1) cycles, which gives a serial clock of the module clock divided by 2^E.
- R5: In power-of-two mode with E = 0, `tick_o` is high on every cycle while the block is enabled.
- R6: While `en_i` is low no pulse is produced and the count is held at zero. After `en_i` rises, the first pulse is seen P cycles later, where P is the tick period.
- R7: A `start_i` pulse suppresses `tick_o` in the following cycle. The next pulse then comes exactly P cycles after the start edge.
- R8: A control write also restarts the count, and the new setting is in force at once: the first pulse comes P cycles after the write edge, with P taken from the new setting.
- R9: The field that belongs to the mode not selected has no effect on the tick period.
- R10: When P > 1 each pulse lasts exactly one cycle, and successive pulses are P cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Transfer active; a low level holds the divider idle |
| start_i | input | 1 | Single-cycle restart at the beginning of a transfer |
| cfg_we_i | input | 1 | Control word write strobe |
| cfg_wdata_i | input | 13 | Control word write data |
| cfg_rdata_o | output | 13 | Current control word |
| tick_o | output | 1 | Enable pulse at twice the serial clock rate |

## Verification
The bench sweeps all 256 linear divisors and all 16 exponents. For each setting it measures the cycle distance from the write edge to the first pulse, and then the distance from that pulse to the next. An off-by-one in either divide formula shows up as a wrong interval. A design that does not clear its count on a write gives a short or long first interval. Exponents 0 and 1 must both give a pulse on every cycle; a design that treats E = 0 as 2^-1 or wraps its mask fails there. Both sweeps place unrelated values in the unused field to catch a decoder that mixes the two fields. Further cases restart the divider part-way through a period with `start_i` and with a dropped `en_i`; a design that keeps a stale count there fires early.

// File: rtl/spi_tick_pkg.sv
package spi_tick_pkg;
  localparam int unsigned DEF_N_W = 8;
  localparam int unsigned DEF_E_W = 4;

  function automatic int unsigned cnt_width(int unsigned n_w, int unsigned e_w);
    int unsigned pw;
    pw = (1 << e_w) - 1;
    return (n_w > pw) ? n_w : pw;
  endfunction
endpackage

// File: rtl/spi_tick_cfg.sv
module spi_tick_cfg #(
  parameter int unsigned N_W   = 8,
  parameter int unsigned E_W   = 4,
  localparam int unsigned CFG_W = N_W + E_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic [CFG_W-1:0] rdata_o,
  output logic [N_W-1:0]   div_n_o,
  output logic [E_W-1:0]   exp_o,
  output logic             lin_o
);
  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= '0;
    else if (we_i) cfg_q <= wdata_i;
  end

  assign rdata_o = cfg_q;
  assign div_n_o = cfg_q[N_W-1:0];
  assign exp_o   = cfg_q[N_W+E_W-1:N_W];
  assign lin_o   = cfg_q[CFG_W-1];

  // R2: written word visible on the next cycle
  a_r2_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> rdata_o == $past(wdata_i));
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(rdata_o));
endmodule

// File: rtl/spi_tick_period.sv
module spi_tick_period #(
  parameter int unsigned N_W   = 8,
  parameter int unsigned E_W   = 4,
  parameter int unsigned CNT_W = 15
) (
  input  logic [N_W-1:0]   div_n_i,
  input  logic [E_W-1:0]   exp_i,
  input  logic             lin_i,
  output logic [CNT_W-1:0] last_o
);
  logic [CNT_W-1:0] last_lin;
  logic [CNT_W-1:0] last_pow;

  // linear: period N+1 -> terminal count N
  assign last_lin = CNT_W'(div_n_i);

  // power of two: period 2^(E-1) -> terminal count is a mask of E-1 ones
  always_comb begin
    for (int i = 0; i < int'(CNT_W); i++)
      last_pow[i] = (i + 1) < int'(exp_i);
  end

  assign last_o = lin_i ? last_lin : last_pow;
endmodule

// File: rtl/spi_tick_count.sv
module spi_tick_count #(
  parameter int unsigned CNT_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] last_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             tick_q;
  logic             at_end;

  assign at_end = (cnt_q == last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      if (clr_i || !en_i || at_end) cnt_q <= '0;
      else                          cnt_q <= cnt_q + 1'b1;
      tick_q <= en_i && !clr_i && at_end;
    end
  end

  assign tick_o = tick_q;

  // R6: idle holds the count and the output
  a_r6_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0) && !tick_o);
  // R7 / R8: restart clears the count and the next output
  a_r7_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0) && !tick_o);
  // R3: count stays within the selected period
  a_r3_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last_i);
  // R10: single-cycle pulse when period exceeds one
  a_r10_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && last_i != '0) |=> !tick_o);
endmodule

// File: rtl/spi_tick_gen.sv
module spi_tick_gen
  import spi_tick_pkg::*;
#(
  parameter int unsigned N_W   = DEF_N_W,
  parameter int unsigned E_W   = DEF_E_W,
  localparam int unsigned CFG_W = N_W + E_W + 1,
  localparam int unsigned CNT_W = cnt_width(N_W, E_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             start_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic [CFG_W-1:0] cfg_rdata_o,
  output logic             tick_o
);
  logic [N_W-1:0]   div_n;
  logic [E_W-1:0]   exp_v;
  logic             lin;
  logic [CNT_W-1:0] last;

  spi_tick_cfg #(.N_W(N_W), .E_W(E_W)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .div_n_o (div_n),
    .exp_o   (exp_v),
    .lin_o   (lin)
  );

  spi_tick_period #(.N_W(N_W), .E_W(E_W), .CNT_W(CNT_W)) u_period (
    .div_n_i (div_n),
    .exp_i   (exp_v),
    .lin_i   (lin),
    .last_o  (last)
  );

  spi_tick_count #(.CNT_W(CNT_W)) u_count (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .clr_i  (start_i || cfg_we_i),
    .last_i (last),
    .tick_o (tick_o)
  );

  // R5: exponent 0 and 1 in power-of-two mode tick every enabled cycle
  a_r5_every_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lin && exp_v <= E_W'(1) && en_i && !start_i && !cfg_we_i) |=> tick_o);
endmodule

// File: tb/spi_tick_gen_test.sv
module spi_tick_gen_test;
  localparam int CFG_W = 13;
  localparam int LIMIT = 190000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             en = 1'b0;
  logic             start = 1'b0;
  logic             we = 1'b0;
  logic [CFG_W-1:0] wdata = '0;
  logic [CFG_W-1:0] rdata;
  logic             tick;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  spi_tick_gen uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .en_i        (en),
    .start_i     (start),
    .cfg_we_i    (we),
    .cfg_wdata_i (wdata),
    .cfg_rdata_o (rdata),
    .tick_o      (tick)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == LIMIT && !done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<%0d", cycles, LIMIT);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // edges counted after the current point until tick is seen at a negedge
  task automatic wait_tick(output int n);
    n = 0;
    do begin
      @(posedge clk);
      @(negedge clk);
      n++;
    end while (!tick && n < 40000);
  endtask

  task automatic write_cfg(input logic [CFG_W-1:0] w);
    wdata = w;
    we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  function automatic int period_of(input logic [CFG_W-1:0] w);
    int e;
    if (w[12]) return int'(w[7:0]) + 1;
    e = int'(w[11:8]);
    return (e <= 1) ? 1 : (1 << (e - 1));
  endfunction

  task automatic measure(input logic [CFG_W-1:0] w, input string req);
    int n;
    int p;
    p = period_of(w);
    write_cfg(w);
    if (p > 1) check(tick == 1'b0, "R8 no tick after write", int'(tick), 0);
    wait_tick(n);
    check(n == p, {req, " first"}, n, p);
    wait_tick(n);
    check(n == p, {req, " interval"}, n, p);
  endtask

  initial begin
    int n;
    #1;
    check(tick == 1'b0 && rdata == '0, "R1 reset", int'(rdata), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(tick == 1'b0 && rdata == '0, "R1 after reset", int'(rdata), 0);

    // R2 layout: only defined bits, readback
    write_cfg(13'h1A5C);
    check(rdata == 13'h1A5C, "R2 readback", int'(rdata), 'h1A5C);

    en = 1'b1;
    // R3 / R9: linear sweep with unrelated exponent values
    for (int d = 0; d < 256; d++) begin
      logic [CFG_W-1:0] w;
      w = {1'b1, 4'(d * 7), 8'(d)};
      measure(w, "R3 R9 linear");
    end
    // R4 / R5 / R9: exponent sweep with unrelated divisor values
    for (int e = 0; e < 16; e++) begin
      logic [CFG_W-1:0] w;
      w = {1'b0, 4'(e), 8'(e * 17 + 3)};
      measure(w, (e == 0) ? "R5 pow2 e0" : "R4 R9 pow2");
    end

    // R10: pulse width with period 6
    write_cfg({1'b1, 4'd0, 8'd5});
    wait_tick(n);
    @(posedge clk);
    @(negedge clk);
    check(tick == 1'b0, "R10 single cycle", int'(tick), 0);

    // R7: restart mid-period with start
    repeat (3) @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check(tick == 1'b0, "R7 no tick after start", int'(tick), 0);
    wait_tick(n);
    check(n == 6, "R7 first after start", n, 6);

    // R6: idle holds everything
    repeat (2) @(negedge clk);
    en = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check(tick == 1'b0, "R6 idle no tick", int'(tick), 0);
    end
    en = 1'b1;
    wait_tick(n);
    check(n == 6, "R6 first after enable", n, 6);

    // R6 with per-cycle period: no tick while idle
    write_cfg({1'b0, 4'd0, 8'd0});
    en = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(tick == 1'b0, "R6 idle e0", int'(tick), 0);

    // R8: write mid-period with a new period
    en = 1'b1;
    write_cfg({1'b1, 4'd0, 8'd9});
    repeat (4) @(negedge clk);
    write_cfg({1'b0, 4'd3, 8'd0});
    wait_tick(n);
    check(n == 4, "R8 new period after write", n, 4);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule